// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the host-visible control state for one channel of a disk-style bus-master DMA engine. A host writes a direction and a start bit through a small byte-addressable register bus. It programs a 32-bit descriptor table base that can be written one lane at a time, and it reads back a status byte. The block turns changes of the start bit into a single launch pulse for an external descriptor walker. It keeps the working table pointer that the walker advances, and it tracks the current memory segment that the walker loads and consumes.

The block owns the channel's status flags. The active flag is set on launch and cleared when the walker reports completion or underrun. The error flag records an underrun. The interrupt flag latches a rising interrupt level from the drive, and that level is forwarded to the host one cycle later. Clearing start does not abort a running transfer; the transfer runs until the walker reports its end.

Register map (byte offsets on `reg_addr`): 0 is the command byte, 2 is the status byte, and 4 to 7 hold the table base. Reads of the command and status bytes return the value in bits 7:0. Every other offset reads zero and ignores writes. Read data appears on `reg_rdata` together with `reg_rvalid` one cycle after the request.

Top module: `bm_dma_ctrl`

## Requirements
- R1: After reset the command, status and base registers read zero, `walk_start` and `host_irq` are low, and the working pointer and segment outputs are zero.
- R2: A command write stores only bit 0 (start) and bit 3 (direction), and every other command bit reads back zero. Writes to offsets 1, 3 and other unmapped offsets change nothing, and reads of those offsets return zero.
- R3: When a command write changes start from 0 to 1 while the channel is idle, the block reloads the working pointer from the base, sets status bit 0 (active), and raises `walk_start` for exactly one cycle. `walk_dir` follows command bit 3.
- R4: A command write that leaves start unchanged issues no `walk_start` and does not reload the working pointer. It still updates the stored direction.
- R5: Clearing start while the channel is active leaves active set.
- R6: A `walk_done` pulse clears active. A 0-to-1 start change while active is still set reloads the working pointer but issues no `walk_start`.
- R7: A `walk_underrun` pulse while active sets status bit 1 (error) and clears active.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit, and writing status bit 0 has no effect. A hardware set in the same cycle as a clear wins.
- R9: A base write at offset 4+k (k=0..3) replaces only the lanes selected by `reg_size` (0 byte, 1 halfword, 2 or 3 word) shifted up by k bytes. The data comes from the low bits of `reg_wdata`, and bits 1:0 of the base always stay zero.
- R10: A base read at offset 4+k returns the base shifted right by k bytes and masked to the access width.
- R11: A rising `drive_irq` sets status bit 2 (interrupt). `host_irq` equals `drive_irq` delayed by one cycle. A high or low level without a rise leaves bit 2 untouched.
- R12: Each `walk_desc_step` pulse advances the working pointer by 8.
- R13: A segment load decodes the length as size bits 15:1 times two, with a zero length meaning 65536. The last flag comes from size bit 31. A take lowers the remaining length by the requested count, clamped to what remains, and advances the segment address by the same amount. A launch clears the segment state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | 3 | Byte offset |
| reg_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| reg_wdata | input | 32 | Write data, low-aligned |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| walk_start | output | 1 | One-cycle launch pulse to the walker |
| walk_dir | output | 1 | Stored direction bit |
| walk_tbl_ptr | output | 32 | Working descriptor table pointer |
| walk_desc_step | input | 1 | Walker consumed one descriptor |
| walk_done | input | 1 | Transfer completed |
| walk_underrun | input | 1 | Transfer ended with an underrun |
| seg_load | input | 1 | Load a new segment |
| seg_addr | input | 32 | Segment start address |
| seg_size | input | 32 | Raw segment size word |
| seg_take | input | 1 | Consume bytes of the segment |
| seg_take_bytes | input | 17 | Bytes to consume |
| seg_cur_addr | output | 32 | Current segment address |
| seg_left | output | 17 | Bytes left in the segment |
| seg_last | output | 1 | Segment is the last in the table |
| drive_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level forwarded to the host |

## Verification
The assertions check the pulse shape of `walk_start` on every cycle. They also check that the pointer it hands off equals the base, that completion and underrun end the active state, that a rising drive interrupt latches the interrupt flag, and that `host_irq` trails the drive by one cycle. The segment tracker and the read port are also watched cycle by cycle. Lane merging and masking of base accesses, the unchanged-start rule, stop without abort, write-one-to-clear priority and segment length decoding depend on specific values, so only the directed scenarios can show them.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;
  localparam int DATA_W     = 32;
  localparam int REG_AW     = 3;
  localparam int DESC_BYTES = 8;
  localparam int SEG_LEN_W  = 17;

  localparam logic [REG_AW-1:0] OFF_CMD  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_STAT = 3'd2;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACTIVE = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    case (acc_size_e'(sz))
      SZ_BYTE: m = DATA_W'(32'h0000_00FF);
      SZ_HALF: m = DATA_W'(32'h0000_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bm_host_if.sv
module bm_host_if
  import bm_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [DATA_W-1:0] cmd_val,
  input  logic [DATA_W-1:0] stat_val,
  input  logic [DATA_W-1:0] base_val,
  output logic              cmd_wr,
  output logic              stat_wr,
  output logic              base_wr,
  output logic [1:0]        base_off,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);
  logic              rd_stb;
  logic              base_sel;
  logic [DATA_W-1:0] rdata_d;

  assign base_sel = reg_addr[REG_AW-1];
  assign base_off = reg_addr[1:0];
  assign cmd_wr   = reg_req && reg_we && (reg_addr == OFF_CMD);
  assign stat_wr  = reg_req && reg_we && (reg_addr == OFF_STAT);
  assign base_wr  = reg_req && reg_we && base_sel;
  assign rd_stb   = reg_req && !reg_we;

  always_comb begin
    rdata_d = '0;
    if (base_sel)
      rdata_d = (base_val >> {base_off, 3'b000}) & lane_mask(reg_size);
    else if (reg_addr == OFF_CMD)
      rdata_d = cmd_val;
    else if (reg_addr == OFF_STAT)
      rdata_d = stat_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rvalid <= 1'b0;
    else        reg_rvalid <= rd_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (rd_stb) reg_rdata <= rdata_d;
  end

  assert_rvalid_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> $past(reg_req && !reg_we));
endmodule

// File: rtl/bm_base_reg.sv
module bm_base_reg
  import bm_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        off,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_q
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(3);

  logic [DATA_W-1:0] lane_m;
  logic [DATA_W-1:0] lane_d;
  logic [DATA_W-1:0] base_d;

  always_comb begin
    lane_m = lane_mask(size) << {off, 3'b000};
    lane_d = (wdata & lane_mask(size)) << {off, 3'b000};
    base_d = ((base_q & ~lane_m) | (lane_d & lane_m)) & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  base_q <= '0;
    else if (wr) base_q <= base_d;
  end

  assert_base_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(base_q));
endmodule

// File: rtl/bm_seg_track.sv
module bm_seg_track
  import bm_dma_pkg::*;
#(
  parameter int AW = DATA_W,
  parameter int LW = SEG_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DATA_W-1:0] ld_size,
  input  logic              take,
  input  logic [LW-1:0]     take_bytes,
  output logic [AW-1:0]     cur_addr,
  output logic [LW-1:0]     left,
  output logic              last
);
  localparam logic [LW-1:0] FULL_LEN = LW'(1) << (LW - 1);

  logic [LW-1:0] len_dec;
  logic [LW-1:0] take_amt;
  logic [AW-1:0] addr_d;
  logic [LW-1:0] left_d;
  logic          last_d;
  logic          upd_en;

  always_comb begin
    len_dec = {1'b0, ld_size[LW-2:1], 1'b0};
    if (len_dec == '0) len_dec = FULL_LEN;
    take_amt = (take_bytes > left) ? left : take_bytes;
  end

  always_comb begin
    addr_d = cur_addr;
    left_d = left;
    last_d = last;
    if (clr) begin
      addr_d = '0;
      left_d = '0;
      last_d = 1'b0;
    end else if (load) begin
      addr_d = ld_addr;
      left_d = len_dec;
      last_d = ld_size[DATA_W-1];
    end else if (take) begin
      addr_d = cur_addr + AW'(take_amt);
      left_d = left - take_amt;
    end
  end

  assign upd_en = clr || load || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left     <= '0;
      last     <= 1'b0;
    end else if (upd_en) begin
      cur_addr <= addr_d;
      left     <= left_d;
      last     <= last_d;
    end
  end

  assert_seg_load_nonzero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (left != '0));
  assert_seg_take_shrinks_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load && !clr) |=> (left <= $past(left)));
  assert_seg_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (left == '0 && !last));
endmodule

// File: rtl/bm_dma_ctrl.sv
module bm_dma_ctrl
  import bm_dma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [1:0]           reg_size,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_rvalid,
  output logic                 walk_start,
  output logic                 walk_dir,
  output logic [DATA_W-1:0]    walk_tbl_ptr,
  input  logic                 walk_desc_step,
  input  logic                 walk_done,
  input  logic                 walk_underrun,
  input  logic                 seg_load,
  input  logic [DATA_W-1:0]    seg_addr,
  input  logic [DATA_W-1:0]    seg_size,
  input  logic                 seg_take,
  input  logic [SEG_LEN_W-1:0] seg_take_bytes,
  output logic [DATA_W-1:0]    seg_cur_addr,
  output logic [SEG_LEN_W-1:0] seg_left,
  output logic                 seg_last,
  input  logic                 drive_irq,
  output logic                 host_irq
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[RST_STAGES-1];

  logic              cmd_wr, stat_wr, base_wr;
  logic [1:0]        base_off;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] cmd_val, stat_val;

  logic cmd_start_q, cmd_dir_q;
  logic cmd_start_d, cmd_dir_d;
  logic st_active_q, st_err_q, st_int_q;
  logic st_active_d, st_err_d, st_int_d;
  logic irq_q, host_irq_q, walk_start_q;
  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic ptr_en, st_en;
  logic start_rise, launch, irq_rise;

  bm_host_if u_host_if (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_size   (reg_size),
    .cmd_val    (cmd_val),
    .stat_val   (stat_val),
    .base_val   (base_q),
    .cmd_wr     (cmd_wr),
    .stat_wr    (stat_wr),
    .base_wr    (base_wr),
    .base_off   (base_off),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  bm_base_reg u_base_reg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr     (base_wr),
    .off    (base_off),
    .size   (reg_size),
    .wdata  (reg_wdata),
    .base_q (base_q)
  );

  bm_seg_track #(.AW(DATA_W), .LW(SEG_LEN_W)) u_seg_track (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (launch),
    .load       (seg_load),
    .ld_addr    (seg_addr),
    .ld_size    (seg_size),
    .take       (seg_take),
    .take_bytes (seg_take_bytes),
    .cur_addr   (seg_cur_addr),
    .left       (seg_left),
    .last       (seg_last)
  );

  // read-back views
  always_comb begin
    cmd_val  = '0;
    stat_val = '0;
    cmd_val[CMD_START]  = cmd_start_q;
    cmd_val[CMD_DIR]    = cmd_dir_q;
    stat_val[ST_ACTIVE] = st_active_q;
    stat_val[ST_ERR]    = st_err_q;
    stat_val[ST_INT]    = st_int_q;
  end

  // next-state logic
  always_comb begin
    start_rise  = cmd_wr && reg_wdata[CMD_START] && !cmd_start_q;
    launch      = start_rise && !st_active_q;
    irq_rise    = drive_irq && !irq_q;
    cmd_start_d = reg_wdata[CMD_START];
    cmd_dir_d   = reg_wdata[CMD_DIR];

    st_active_d = st_active_q;
    if (launch)                          st_active_d = 1'b1;
    else if (walk_done || walk_underrun) st_active_d = 1'b0;

    st_err_d = st_err_q;
    if (stat_wr && reg_wdata[ST_ERR])  st_err_d = 1'b0;
    if (walk_underrun && st_active_q)  st_err_d = 1'b1;

    st_int_d = st_int_q;
    if (stat_wr && reg_wdata[ST_INT])  st_int_d = 1'b0;
    if (irq_rise)                      st_int_d = 1'b1;

    ptr_d = ptr_q;
    if (start_rise)          ptr_d = base_q;
    else if (walk_desc_step) ptr_d = ptr_q + DATA_W'(DESC_BYTES);

    ptr_en = start_rise || walk_desc_step;
    st_en  = launch || walk_done || walk_underrun || stat_wr || irq_rise;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_start_q <= 1'b0;
      cmd_dir_q   <= 1'b0;
    end else if (cmd_wr) begin
      cmd_start_q <= cmd_start_d;
      cmd_dir_q   <= cmd_dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_active_q <= 1'b0;
      st_err_q    <= 1'b0;
      st_int_q    <= 1'b0;
    end else if (st_en) begin
      st_active_q <= st_active_d;
      st_err_q    <= st_err_d;
      st_int_q    <= st_int_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_q        <= 1'b0;
      host_irq_q   <= 1'b0;
      walk_start_q <= 1'b0;
    end else begin
      irq_q        <= drive_irq;
      host_irq_q   <= drive_irq;
      walk_start_q <= launch;
    end
  end

  assign walk_start   = walk_start_q;
  assign walk_dir     = cmd_dir_q;
  assign walk_tbl_ptr = ptr_q;
  assign host_irq     = host_irq_q;

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    walk_start |=> !walk_start);
  assert_start_handoff_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    walk_start |-> (st_active_q && walk_tbl_ptr == base_q));
  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (walk_done && st_active_q) |=> !st_active_q);
  assert_underrun_err_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (walk_underrun && st_active_q) |=> (st_err_q && !st_active_q));
  assert_irq_latch_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(drive_irq) |=> st_int_q);
  assert_irq_forward_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (host_irq == $past(drive_irq)));
  assert_step_advance_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (walk_desc_step && !start_rise) |=> (walk_tbl_ptr == $past(walk_tbl_ptr) + DATA_W'(DESC_BYTES)));
endmodule

// File: tb/test_bm_dma_ctrl.sv
module test_bm_dma_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_req, reg_we;
  logic [2:0]  reg_addr;
  logic [1:0]  reg_size;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic        walk_start, walk_dir;
  logic [31:0] walk_tbl_ptr;
  logic        walk_desc_step, walk_done, walk_underrun;
  logic        seg_load, seg_take, seg_last;
  logic [31:0] seg_addr, seg_size, seg_cur_addr;
  logic [16:0] seg_take_bytes, seg_left;
  logic        drive_irq, host_irq;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_dma_ctrl i_bm_dma_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .walk_start(walk_start), .walk_dir(walk_dir), .walk_tbl_ptr(walk_tbl_ptr),
    .walk_desc_step(walk_desc_step), .walk_done(walk_done), .walk_underrun(walk_underrun),
    .seg_load(seg_load), .seg_addr(seg_addr), .seg_size(seg_size),
    .seg_take(seg_take), .seg_take_bytes(seg_take_bytes),
    .seg_cur_addr(seg_cur_addr), .seg_left(seg_left), .seg_last(seg_last),
    .drive_irq(drive_irq), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_size = s; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a; reg_size = s;
    @(negedge clk);
    reg_req = 0;
    v = reg_rdata;
  endtask

  task automatic pulse_step();
    @(negedge clk); walk_desc_step = 1;
    @(negedge clk); walk_desc_step = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); walk_done = 1;
    @(negedge clk); walk_done = 0;
  endtask

  task automatic settle();
    wr(3'd0, 2'd0, 32'h0);
    pulse_done();
    wr(3'd2, 2'd0, 32'h6);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 walk_start", {31'b0, walk_start}, 0);
    chk("R1 host_irq", {31'b0, host_irq}, 0);
    chk("R1 tbl_ptr", walk_tbl_ptr, 0);
    chk("R1 seg_left", {15'b0, seg_left}, 0);
    rd(3'd0, 2'd0, v); chk("R1 cmd", v, 0);
    rd(3'd2, 2'd0, v); chk("R1 status", v, 0);
    rd(3'd4, 2'd2, v); chk("R1 base", v, 0);
  endtask

  task automatic t_cmd_store();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'hFE);
    chk("R2 no launch on bit0=0", {31'b0, walk_start}, 0);
    chk("R2 dir out", {31'b0, walk_dir}, 1);
    rd(3'd0, 2'd0, v); chk("R2 cmd keeps bits 0,3", v, 32'h08);
    wr(3'd1, 2'd0, 32'hFF);
    wr(3'd3, 2'd0, 32'hFF);
    rd(3'd0, 2'd0, v); chk("R2 unmapped write ignored", v, 32'h08);
    rd(3'd2, 2'd0, v); chk("R2 status untouched", v, 32'h00);
    rd(3'd3, 2'd0, v); chk("R2 unmapped reads zero", v, 0);
    wr(3'd0, 2'd0, 32'h00);
  endtask

  task automatic t_base_lanes();
    logic [31:0] v;
    wr(3'd4, 2'd2, 32'h1234_5677);
    rd(3'd4, 2'd2, v); chk("R9 word write low bits zero", v, 32'h1234_5674);
    wr(3'd5, 2'd0, 32'hFFFF_FFAB);
    rd(3'd4, 2'd2, v); chk("R9 byte lane 1", v, 32'h1234_AB74);
    wr(3'd6, 2'd1, 32'h0000_CDEF);
    rd(3'd4, 2'd2, v); chk("R9 half lanes 2-3", v, 32'hCDEF_AB74);
    wr(3'd4, 2'd0, 32'h0000_00FF);
    rd(3'd4, 2'd2, v); chk("R9 byte lane 0 forced align", v, 32'hCDEF_ABFC);
    rd(3'd5, 2'd0, v); chk("R10 byte read off1", v, 32'h0000_00AB);
    rd(3'd6, 2'd1, v); chk("R10 half read off2", v, 32'h0000_CDEF);
    rd(3'd5, 2'd2, v); chk("R10 word read off1", v, 32'h00CD_EFAB);
  endtask

  task automatic t_launch();
    logic [31:0] v;
    settle();
    wr(3'd4, 2'd2, 32'h0000_1000);
    wr(3'd0, 2'd0, 32'h09);
    chk("R3 walk_start high", {31'b0, walk_start}, 1);
    chk("R3 pointer reload", walk_tbl_ptr, 32'h1000);
    chk("R3 dir", {31'b0, walk_dir}, 1);
    @(negedge clk);
    chk("R3 walk_start one cycle", {31'b0, walk_start}, 0);
    rd(3'd2, 2'd0, v); chk("R3 active set", v, 32'h01);
    pulse_step();
    pulse_step();
    chk("R12 pointer +16", walk_tbl_ptr, 32'h1010);
  endtask

  task automatic t_same_start();
    logic [31:0] v;
    wr(3'd4, 2'd2, 32'h0000_2000);
    wr(3'd0, 2'd0, 32'h01);
    chk("R4 no launch", {31'b0, walk_start}, 0);
    chk("R4 pointer kept", walk_tbl_ptr, 32'h1010);
    chk("R4 dir updated", {31'b0, walk_dir}, 0);
    rd(3'd0, 2'd0, v); chk("R4 cmd readback", v, 32'h01);
  endtask

  task automatic t_stop_done();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'h00);
    chk("R5 no launch on stop", {31'b0, walk_start}, 0);
    rd(3'd2, 2'd0, v); chk("R5 active kept after stop", v, 32'h01);
    pulse_done();
    rd(3'd2, 2'd0, v); chk("R6 done clears active", v, 32'h00);
    wr(3'd0, 2'd0, 32'h01);
    chk("R3 relaunch", {31'b0, walk_start}, 1);
    chk("R3 relaunch pointer", walk_tbl_ptr, 32'h2000);
    pulse_step();
    chk("R12 pointer +8", walk_tbl_ptr, 32'h2008);
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h01);
    chk("R6 no pulse while active", {31'b0, walk_start}, 0);
    chk("R6 pointer reload while active", walk_tbl_ptr, 32'h2000);
    rd(3'd2, 2'd0, v); chk("R6 still active", v, 32'h01);
    pulse_done();
    rd(3'd2, 2'd0, v); chk("R6 done clears", v, 32'h00);
  endtask

  task automatic t_underrun_status();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h01);
    @(negedge clk); walk_underrun = 1;
    @(negedge clk); walk_underrun = 0;
    rd(3'd2, 2'd0, v); chk("R7 underrun err, not active", v, 32'h02);
    wr(3'd2, 2'd0, 32'h02);
    rd(3'd2, 2'd0, v); chk("R8 err cleared by W1C", v, 32'h00);
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h01);
    wr(3'd2, 2'd0, 32'hFF);
    rd(3'd2, 2'd0, v); chk("R8 active read-only", v, 32'h01);
    @(negedge clk);
    walk_underrun = 1;
    reg_req = 1; reg_we = 1; reg_addr = 3'd2; reg_size = 2'd0; reg_wdata = 32'h02;
    @(negedge clk);
    walk_underrun = 0; reg_req = 0; reg_we = 0;
    rd(3'd2, 2'd0, v); chk("R8 set wins over clear", v, 32'h02);
    wr(3'd2, 2'd0, 32'h02);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk); drive_irq = 1;
    @(negedge clk);
    chk("R11 host_irq follows", {31'b0, host_irq}, 1);
    rd(3'd2, 2'd0, v); chk("R11 int set on rise", v, 32'h04);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, v); chk("R11 steady high no reset of int", v, 32'h00);
    wr(3'd2, 2'd0, 32'h00);
    drive_irq = 1;
    @(negedge clk); drive_irq = 0;
    @(negedge clk);
    chk("R11 host_irq low", {31'b0, host_irq}, 0);
    rd(3'd2, 2'd0, v); chk("R11 low level leaves int", v, 32'h00);
    @(negedge clk); drive_irq = 1;
    @(negedge clk); drive_irq = 0;
    @(negedge clk);
    rd(3'd2, 2'd0, v); chk("R11 low after rise keeps int", v, 32'h04);
    wr(3'd2, 2'd0, 32'h04);
  endtask

  task automatic t_segments();
    @(negedge clk);
    seg_load = 1; seg_addr = 32'h3000; seg_size = 32'h8000_0000;
    @(negedge clk); seg_load = 0;
    chk("R13 zero len is 65536", {15'b0, seg_left}, 32'h10000);
    chk("R13 last flag", {31'b0, seg_last}, 1);
    chk("R13 addr", seg_cur_addr, 32'h3000);
    @(negedge clk);
    seg_load = 1; seg_addr = 32'h4000; seg_size = 32'h0000_0203;
    @(negedge clk); seg_load = 0;
    chk("R13 len even", {15'b0, seg_left}, 32'h202);
    chk("R13 not last", {31'b0, seg_last}, 0);
    @(negedge clk); seg_take = 1; seg_take_bytes = 17'h100;
    @(negedge clk); seg_take = 0;
    chk("R13 take left", {15'b0, seg_left}, 32'h102);
    chk("R13 take addr", seg_cur_addr, 32'h4100);
    @(negedge clk); seg_take = 1; seg_take_bytes = 17'h200;
    @(negedge clk); seg_take = 0;
    chk("R13 take clamp", {15'b0, seg_left}, 0);
    chk("R13 clamp addr", seg_cur_addr, 32'h4202);
    @(negedge clk);
    seg_load = 1; seg_addr = 32'h5000; seg_size = 32'h8000_0010;
    @(negedge clk); seg_load = 0;
    settle();
    wr(3'd0, 2'd0, 32'h01);
    chk("R13 launch clears left", {15'b0, seg_left}, 0);
    chk("R13 launch clears last", {31'b0, seg_last}, 0);
    chk("R13 launch clears addr", seg_cur_addr, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0;
    reg_req = 0; reg_we = 0; reg_addr = '0; reg_size = '0; reg_wdata = '0;
    walk_desc_step = 0; walk_done = 0; walk_underrun = 0;
    seg_load = 0; seg_addr = '0; seg_size = '0; seg_take = 0; seg_take_bytes = '0;
    drive_irq = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cmd_store();
    t_base_lanes();
    t_launch();
    t_same_start();
    t_stop_done();
    t_underrun_status();
    t_irq();
    t_segments();
    finish_run();
  end
endmodule